// File: doc/BRIEF.md
# Synchronous Serial Receive Start and Framing Controller

This block decides when a synchronous serial receiver is capturing data. It runs in the receive-clock domain. It watches an asynchronous frame-sync line through a two-stage synchronizer and picks a start trigger from a 4-bit selector. The trigger can be free running, the transmitter's start, a level, an edge or any change of the sync line, or a compare-0 match from the pattern matcher. An optional delay counter places a programmable number of receive clocks between the trigger and the moment the capture window (`rx_active`) opens.

Once capture is running, the stop rule depends on the selector. Free-running mode never closes the window. Compare-0 mode closes it either after a single word or on a compare-1 match, chosen by `stop_on_cmp1`. Every other trigger closes the window at the end of the current word, and the block then waits for the next trigger. Two further outputs share the synchronized sync line and the receive clock. One is a clock-enable qualifier, which can follow the low or the high level of the sync line. The other is a one-clock frame pulse produced by a programmable divider. The shift register and the compare logic sit outside this block. They supply `word_done`, `cmp0_hit` and `cmp1_hit` as one-clock pulses.

Top module: `rxs_start_ctrl`

## Requirements
- R1: With `start_sel` = 0, `rx_active` rises one clock after `rx_en` is first sampled high. While enabled it stays high, and `word_done` has no effect on it.
- R2: With `start_sel` = 1, a `tx_start` pulse raises `rx_active` one clock after it is sampled (zero delay). A `word_done` pulse then drops `rx_active` one clock after it is sampled, and the block waits for another `tx_start`.
- R3: With `start_sel` = 2 (sync low) or 3 (sync high), capture starts three clocks after `sync_in` is first driven to the selected level. Two clocks of this come from the synchronizer and one from the state register. The other level does not start capture.
- R4: With `start_sel` = 4 (falling edge) or 5 (rising edge), capture starts three clocks after the selected transition of `sync_in`. The opposite transition does not start it.
- R5: With `start_sel` = 6 or 7, either transition of `sync_in` starts capture three clocks later. A `sync_in` line that holds steady does not start capture.
- R6: With `start_sel` = 8 and `stop_on_cmp1` = 0, a `cmp0_hit` pulse starts capture one clock later. The next `word_done` ends it one clock after it is sampled. Capture stays off until another `cmp0_hit` arrives.
- R7: With `start_sel` = 8 and `stop_on_cmp1` = 1, `word_done` does not end capture. A `cmp1_hit` pulse ends it one clock after it is sampled.
- R8: Selector values 9 to 15 never start capture, whatever `tx_start`, `cmp0_hit` and `sync_in` do.
- R9: A nonzero `start_dly` value D delays the opening of capture by D clocks. A pulse trigger then raises `rx_active` 1+D clocks after the pulse is sampled. This holds for the transmitter trigger as well as the compare-0 trigger.
- R10: When `rx_en` is sampled low, `rx_active` is low on the next clock. Any delay count in progress is discarded, so capture does not open later.
- R11: With `period_div` = 0, `period_pulse` never fires. With `period_div` = N > 0, `period_pulse` is exactly one clock wide and repeats every 2*(N+1) clocks.
- R12: Writing a new `period_div` value restarts the divider. The first pulse comes 2*(N+1) clocks after the new value is applied, and the old count is not finished.
- R13: `gate_sel` = 1 drives `clk_en` high only while the synchronized sync line is low. `gate_sel` = 2 drives it high only while that line is high. Values 0 and 3 hold `clk_en` high. The synchronized line trails `sync_in` by two clocks.
- R14: After reset, `rx_active` and `period_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low forces idle |
| start_sel | input | 4 | Start trigger selector (0..8 valid, 9..15 inert) |
| stop_on_cmp1 | input | 1 | Compare-0 mode: 0 = stop after one word, 1 = stop on compare-1 |
| start_dly | input | DLY_W | Clocks inserted between trigger and capture |
| period_div | input | PER_W | Frame-pulse divider, 0 disables |
| gate_sel | input | 2 | Clock-enable mode (0 free, 1 sync low, 2 sync high, 3 free) |
| sync_in | input | 1 | Asynchronous frame-sync line |
| tx_start | input | 1 | Transmitter start pulse |
| cmp0_hit | input | 1 | Compare-0 match pulse |
| cmp1_hit | input | 1 | Compare-1 match pulse |
| word_done | input | 1 | End-of-word strobe |
| rx_active | output | 1 | Capture window open |
| clk_en | output | 1 | Receive clock qualifier |
| period_pulse | output | 1 | One-clock frame-sync pulse |

## Verification
The bench aims at the timing boundaries. It checks the exact clock at which capture opens after a delayed pulse trigger. An off-by-one delay counter would open one clock early or late. It drops `rx_en` while a delay count is still running, and a design that kept the stale count would open capture later anyway. It drives the wrong edge for the edge modes and steady lines for the change modes, and fires triggers under reserved selector codes. An edge detector or decoder with a fault would then open capture. It rewrites the divider mid-count to show that the old count is discarded, and it checks that `word_done` is ignored in free-running mode and in compare-1 stop mode. In those two modes a merged stop rule would close the window early.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    // Start trigger selector codes; the numbering is the external encoding.
    localparam logic [3:0] SEL_CONT   = 4'h0;
    localparam logic [3:0] SEL_TXGO   = 4'h1;
    localparam logic [3:0] SEL_LVL_LO = 4'h2;
    localparam logic [3:0] SEL_LVL_HI = 4'h3;
    localparam logic [3:0] SEL_FALL   = 4'h4;
    localparam logic [3:0] SEL_RISE   = 4'h5;
    localparam logic [3:0] SEL_CHANGE = 4'h6;
    localparam logic [3:0] SEL_EDGE   = 4'h7;
    localparam logic [3:0] SEL_CMP0   = 4'h8;

    typedef enum logic [1:0] {
        GATE_FREE = 2'd0,
        GATE_LOW  = 2'd1,
        GATE_HIGH = 2'd2,
        GATE_RSVD = 2'd3
    } gate_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    // Events derived from the synchronized frame-sync line.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
        logic toggle;
    } sync_evt_t;

    function automatic logic start_hit(
        input logic [3:0] sel,
        input sync_evt_t  ev,
        input logic       tx_go,
        input logic       cmp0
    );
        case (sel)
            SEL_CONT:   start_hit = 1'b1;
            SEL_TXGO:   start_hit = tx_go;
            SEL_LVL_LO: start_hit = ~ev.level;
            SEL_LVL_HI: start_hit = ev.level;
            SEL_FALL:   start_hit = ev.fall;
            SEL_RISE:   start_hit = ev.rise;
            SEL_CHANGE: start_hit = ev.toggle;
            SEL_EDGE:   start_hit = ev.toggle;
            SEL_CMP0:   start_hit = cmp0;
            default:    start_hit = 1'b0;
        endcase
    endfunction

    function automatic logic stop_hit(
        input logic [3:0] sel,
        input logic       on_cmp1,
        input logic       word_end,
        input logic       cmp1
    );
        if (sel == SEL_CONT)
            stop_hit = 1'b0;
        else if (sel == SEL_CMP0 && on_cmp1)
            stop_hit = cmp1;
        else
            stop_hit = word_end;
    endfunction

endpackage

// File: rtl/rxs_sync_edge.sv
module rxs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                din,
    output rxs_pkg::sync_evt_t  evt
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        evt.level  = chain_q[STAGES-1];
        evt.rise   = chain_q[STAGES-1] & ~prev_q;
        evt.fall   = ~chain_q[STAGES-1] & prev_q;
        evt.toggle = chain_q[STAGES-1] ^ prev_q;
    end
endmodule

// File: rtl/rxs_seq.sv
module rxs_seq #(
    parameter int DLY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [3:0]         start_sel,
    input  logic               stop_on_cmp1,
    input  logic [DLY_W-1:0]   start_dly,
    input  rxs_pkg::sync_evt_t evt,
    input  logic               tx_start,
    input  logic               cmp0_hit,
    input  logic               cmp1_hit,
    input  logic               word_done,
    output logic               rx_active
);
    import rxs_pkg::*;

    localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

    seq_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             go_now, end_now;

    always_comb begin
        go_now  = start_hit(start_sel, evt, tx_start, cmp0_hit);
        end_now = stop_hit(start_sel, stop_on_cmp1, word_done, cmp1_hit);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go_now) begin
                        if (start_dly == '0) begin
                            state_d = ST_RUN;
                        end else begin
                            state_d = ST_DELAY;
                            cnt_d   = start_dly;
                        end
                    end
                end
                ST_DELAY: begin
                    if (cnt_q <= CNT_ONE) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                ST_RUN: begin
                    if (end_now)
                        state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign rx_active = (state_q == ST_RUN);
endmodule

// File: rtl/rxs_period_gen.sv
module rxs_period_gen #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period_div,
    output logic             period_pulse
);
    localparam int CNT_W = PER_W + 1;

    logic [PER_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // 2*(N+1) clocks per frame: count 0 .. 2N+1.
    assign last_cnt = {div_q, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (period_div != div_q) begin
            div_q <= period_div;
            cnt_q <= '0;
        end else if (div_q == '0 || cnt_q == last_cnt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign period_pulse = (div_q != '0) && (cnt_q == last_cnt);
endmodule

// File: rtl/rxs_clk_gate.sv
module rxs_clk_gate (
    input  logic [1:0] gate_sel,
    input  logic       sync_level,
    output logic       clk_en
);
    import rxs_pkg::*;

    always_comb begin
        case (gate_mode_e'(gate_sel))
            GATE_LOW:  clk_en = ~sync_level;
            GATE_HIGH: clk_en = sync_level;
            default:   clk_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/rxs_start_ctrl.sv
module rxs_start_ctrl #(
    parameter int DLY_W      = 8,
    parameter int PER_W      = 8,
    parameter int SYNC_STAGE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic [3:0]       start_sel,
    input  logic             stop_on_cmp1,
    input  logic [DLY_W-1:0] start_dly,
    input  logic [PER_W-1:0] period_div,
    input  logic [1:0]       gate_sel,
    input  logic             sync_in,
    input  logic             tx_start,
    input  logic             cmp0_hit,
    input  logic             cmp1_hit,
    input  logic             word_done,
    output logic             rx_active,
    output logic             clk_en,
    output logic             period_pulse
);
    import rxs_pkg::*;

    sync_evt_t sync_evt;

    rxs_sync_edge #(.STAGES(SYNC_STAGE)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (sync_in),
        .evt (sync_evt)
    );

    rxs_seq #(.DLY_W(DLY_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .en           (rx_en),
        .start_sel    (start_sel),
        .stop_on_cmp1 (stop_on_cmp1),
        .start_dly    (start_dly),
        .evt          (sync_evt),
        .tx_start     (tx_start),
        .cmp0_hit     (cmp0_hit),
        .cmp1_hit     (cmp1_hit),
        .word_done    (word_done),
        .rx_active    (rx_active)
    );

    rxs_period_gen #(.PER_W(PER_W)) u_period (
        .clk          (clk),
        .rst          (rst),
        .period_div   (period_div),
        .period_pulse (period_pulse)
    );

    rxs_clk_gate u_gate (
        .gate_sel   (gate_sel),
        .sync_level (sync_evt.level),
        .clk_en     (clk_en)
    );
endmodule

// File: rtl/rxs_start_ctrl_chk.sv
module rxs_start_ctrl_chk #(
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic [3:0]       start_sel,
    input logic             stop_on_cmp1,
    input logic             cmp1_hit,
    input logic [PER_W-1:0] period_div,
    input logic [1:0]       gate_sel,
    input logic             sync_in,
    input logic             rx_active,
    input logic             clk_en,
    input logic             period_pulse
);
    import rxs_pkg::*;

    // Clocks since reset, saturating; guards looks into the past.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)
            age_q <= 2'd0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_active);

    assert_cont_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rx_active && start_sel == SEL_CONT) |=> rx_active);

    assert_cmp1_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rx_active && start_sel == SEL_CMP0 && stop_on_cmp1 && !cmp1_hit)
        |=> rx_active);

    assert_pulse_width_R11: assert property (@(posedge clk) disable iff (rst)
        period_pulse |=> !period_pulse);

    assert_no_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (period_div == '0 && $past(period_div) == '0) |-> !period_pulse);

    assert_gate_low_R13: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && gate_sel == GATE_LOW) |-> (clk_en == !$past(sync_in, 2)));

    assert_gate_high_R13: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && gate_sel == GATE_HIGH) |-> (clk_en == $past(sync_in, 2)));

    assert_gate_free_R13: assert property (@(posedge clk) disable iff (rst)
        (gate_sel == GATE_FREE || gate_sel == GATE_RSVD) |-> clk_en);
endmodule

bind rxs_start_ctrl rxs_start_ctrl_chk #(.PER_W(PER_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .rx_en        (rx_en),
    .start_sel    (start_sel),
    .stop_on_cmp1 (stop_on_cmp1),
    .cmp1_hit     (cmp1_hit),
    .period_div   (period_div),
    .gate_sel     (gate_sel),
    .sync_in      (sync_in),
    .rx_active    (rx_active),
    .clk_en       (clk_en),
    .period_pulse (period_pulse)
);

// File: tb/rxs_start_ctrl_tb_top.sv
`timescale 1ns/1ps
module rxs_start_ctrl_tb_top;
    localparam int DLY_W = 8;
    localparam int PER_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             rx_en;
    logic [3:0]       start_sel;
    logic             stop_on_cmp1;
    logic [DLY_W-1:0] start_dly;
    logic [PER_W-1:0] period_div;
    logic [1:0]       gate_sel;
    logic             sync_in;
    logic             tx_start;
    logic             cmp0_hit;
    logic             cmp1_hit;
    logic             word_done;
    logic             rx_active;
    logic             clk_en;
    logic             period_pulse;

    always #2 clk = ~clk;

    rxs_start_ctrl #(.DLY_W(DLY_W), .PER_W(PER_W)) dut_i (
        .clk (clk), .rst (rst), .rx_en (rx_en), .start_sel (start_sel),
        .stop_on_cmp1 (stop_on_cmp1), .start_dly (start_dly),
        .period_div (period_div), .gate_sel (gate_sel), .sync_in (sync_in),
        .tx_start (tx_start), .cmp0_hit (cmp0_hit), .cmp1_hit (cmp1_hit),
        .word_done (word_done), .rx_active (rx_active), .clk_en (clk_en),
        .period_pulse (period_pulse)
    );

    // Scoreboard item: expected value of one output at one cycle.
    typedef struct {
        int    cyc;
        int    sig;    // 0 rx_active, 1 clk_en, 2 period_pulse
        bit    val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc      = 0;
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops items that fall due in this cycle and compares.
    always @(negedge clk) begin
        exp_t keep[$];
        logic act;
        keep = {};
        foreach (exp_q[i]) begin
            if (exp_q[i].cyc <= cyc) begin
                case (exp_q[i].sig)
                    0:       act = rx_active;
                    1:       act = clk_en;
                    default: act = period_pulse;
                endcase
                checks++;
                if (act !== exp_q[i].val) begin
                    failures++;
                    $display("FAIL %s cycle %0d sig %0d actual=%b expected=%b",
                             exp_q[i].req, cyc, exp_q[i].sig, act, exp_q[i].val);
                end
            end else begin
                keep.push_back(exp_q[i]);
            end
        end
        exp_q = keep;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(int d, int sig, bit v, string req);
        exp_t e;
        e.cyc = cyc + d;
        e.sig = sig;
        e.val = v;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle_cfg(logic [3:0] sel, logic stop, logic [DLY_W-1:0] dly);
        rx_en = 1'b0;
        tick();
        start_sel    = sel;
        stop_on_cmp1 = stop;
        start_dly    = dly;
        tick();
        tick();
    endtask

    task automatic pulse_tx();
        tx_start = 1'b1;
        tick();
        tx_start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rx_en = 1'b0; start_sel = 4'h0; stop_on_cmp1 = 1'b0;
        start_dly = '0; period_div = '0; gate_sel = 2'd0; sync_in = 1'b0;
        tx_start = 1'b0; cmp0_hit = 1'b0; cmp1_hit = 1'b0; word_done = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        expect_at(1, 0, 1'b0, "R14");
        expect_at(1, 2, 1'b0, "R14");
        expect_at(1, 1, 1'b1, "R13");
        tick(); tick();

        // R1 free running, word_done ignored
        start_sel = 4'h0; rx_en = 1'b1;
        expect_at(0, 0, 1'b0, "R1");
        expect_at(1, 0, 1'b1, "R1");
        tick();
        word_done = 1'b1;
        expect_at(1, 0, 1'b1, "R1");
        expect_at(2, 0, 1'b1, "R1");
        tick(); word_done = 1'b0; tick(); tick();

        // R2 transmitter start, word end stops
        idle_cfg(4'h1, 1'b0, '0);
        rx_en = 1'b1; tick(); tick();
        expect_at(0, 0, 1'b0, "R2");
        tx_start = 1'b1;
        expect_at(1, 0, 1'b1, "R2");
        tick(); tx_start = 1'b0; tick();
        word_done = 1'b1;
        expect_at(1, 0, 1'b0, "R2");
        tick(); word_done = 1'b0;
        expect_at(2, 0, 1'b0, "R2");
        tick(); tick();

        // R9 delay with transmitter start
        idle_cfg(4'h1, 1'b0, 8'd3);
        rx_en = 1'b1; tick();
        expect_at(3, 0, 1'b0, "R9");
        expect_at(4, 0, 1'b1, "R9");
        pulse_tx();
        repeat (5) tick();

        // R9 delay with compare-0 start
        idle_cfg(4'h8, 1'b0, 8'd2);
        rx_en = 1'b1; tick();
        cmp0_hit = 1'b1;
        expect_at(2, 0, 1'b0, "R9");
        expect_at(3, 0, 1'b1, "R9");
        tick(); cmp0_hit = 1'b0;
        repeat (4) tick();

        // R10 abort during delay count
        idle_cfg(4'h1, 1'b0, 8'd5);
        rx_en = 1'b1; tick();
        pulse_tx(); tick();
        rx_en = 1'b0;
        for (int d = 1; d <= 8; d++) expect_at(d, 0, 1'b0, "R10");
        repeat (8) tick();
        // R10 abort while running
        idle_cfg(4'h0, 1'b0, '0);
        rx_en = 1'b1; tick(); tick();
        expect_at(0, 0, 1'b1, "R10");
        rx_en = 1'b0;
        expect_at(1, 0, 1'b0, "R10");
        tick(); tick();

        // R3 low level
        sync_in = 1'b1;
        idle_cfg(4'h2, 1'b0, '0);
        tick();
        rx_en = 1'b1; tick(); tick(); tick();
        expect_at(0, 0, 1'b0, "R3");
        sync_in = 1'b0;
        expect_at(2, 0, 1'b0, "R3");
        expect_at(3, 0, 1'b1, "R3");
        repeat (4) tick();
        // R3 high level
        rx_en = 1'b0; tick();
        start_sel = 4'h3; tick(); tick();
        rx_en = 1'b1; tick(); tick();
        expect_at(0, 0, 1'b0, "R3");
        sync_in = 1'b1;
        expect_at(2, 0, 1'b0, "R3");
        expect_at(3, 0, 1'b1, "R3");
        repeat (4) tick();

        // R4 falling edge: rising edge ignored first
        rx_en = 1'b0; sync_in = 1'b0; tick();
        start_sel = 4'h4; repeat (3) tick();
        rx_en = 1'b1; tick();
        sync_in = 1'b1;
        for (int d = 3; d <= 5; d++) expect_at(d, 0, 1'b0, "R4");
        repeat (5) tick();
        sync_in = 1'b0;
        expect_at(2, 0, 1'b0, "R4");
        expect_at(3, 0, 1'b1, "R4");
        repeat (4) tick();
        // R4 rising edge
        rx_en = 1'b0; tick();
        start_sel = 4'h5; repeat (3) tick();
        rx_en = 1'b1; tick();
        sync_in = 1'b1;
        expect_at(3, 0, 1'b1, "R4");
        repeat (4) tick();
        // R4 rising mode ignores falling edge
        rx_en = 1'b0; tick(); tick(); tick();
        rx_en = 1'b1; tick();
        sync_in = 1'b0;
        for (int d = 3; d <= 5; d++) expect_at(d, 0, 1'b0, "R4");
        repeat (5) tick();

        // R5 any change, both directions
        rx_en = 1'b0; tick();
        start_sel = 4'h6; tick(); tick();
        rx_en = 1'b1; tick();
        expect_at(2, 0, 1'b0, "R5");
        tick(); tick();
        sync_in = 1'b1;
        expect_at(3, 0, 1'b1, "R5");
        repeat (4) tick();
        rx_en = 1'b0; tick();
        start_sel = 4'h7; tick(); tick();
        rx_en = 1'b1; tick();
        expect_at(0, 0, 1'b0, "R5");
        sync_in = 1'b0;
        expect_at(3, 0, 1'b1, "R5");
        repeat (4) tick();

        // R6 compare-0 start, single word
        idle_cfg(4'h8, 1'b0, '0);
        rx_en = 1'b1; tick();
        expect_at(0, 0, 1'b0, "R6");
        cmp0_hit = 1'b1;
        expect_at(1, 0, 1'b1, "R6");
        tick(); cmp0_hit = 1'b0; tick();
        word_done = 1'b1;
        expect_at(1, 0, 1'b0, "R6");
        tick(); word_done = 1'b0;
        expect_at(3, 0, 1'b0, "R6");
        repeat (3) tick();
        cmp0_hit = 1'b1;
        expect_at(1, 0, 1'b1, "R6");
        tick(); cmp0_hit = 1'b0; tick();

        // R7 compare-0 start, compare-1 stop
        rx_en = 1'b0; tick();
        stop_on_cmp1 = 1'b1; tick();
        rx_en = 1'b1; tick();
        cmp0_hit = 1'b1;
        expect_at(1, 0, 1'b1, "R7");
        tick(); cmp0_hit = 1'b0; tick();
        word_done = 1'b1;
        expect_at(1, 0, 1'b1, "R7");
        tick(); word_done = 1'b0; tick();
        cmp1_hit = 1'b1;
        expect_at(1, 0, 1'b0, "R7");
        tick(); cmp1_hit = 1'b0;
        expect_at(2, 0, 1'b0, "R7");
        repeat (3) tick();

        // R8 reserved selectors
        for (int k = 0; k < 2; k++) begin
            idle_cfg((k == 0) ? 4'h9 : 4'hF, 1'b0, '0);
            rx_en = 1'b1;
            for (int d = 1; d <= 9; d++) expect_at(d, 0, 1'b0, "R8");
            tick();
            tx_start = 1'b1; cmp0_hit = 1'b1;
            tick();
            tx_start = 1'b0; cmp0_hit = 1'b0; sync_in = 1'b1;
            repeat (3) tick();
            sync_in = 1'b0;
            repeat (4) tick();
        end
        rx_en = 1'b0; tick();

        // R11 divider N=2: period 6
        period_div = 8'd2;
        expect_at(5, 2, 1'b0, "R11");
        expect_at(6, 2, 1'b1, "R11");
        expect_at(7, 2, 1'b0, "R11");
        expect_at(11, 2, 1'b0, "R11");
        expect_at(12, 2, 1'b1, "R11");
        repeat (13) tick();
        // R12 rewrite restarts the count
        period_div = 8'd1;
        expect_at(1, 2, 1'b0, "R12");
        expect_at(3, 2, 1'b0, "R12");
        expect_at(4, 2, 1'b1, "R12");
        expect_at(8, 2, 1'b1, "R12");
        repeat (9) tick();
        // R11 divider zero: no pulse
        period_div = 8'd0;
        for (int d = 1; d <= 20; d++) expect_at(d, 2, 1'b0, "R11");
        repeat (21) tick();

        // R13 clock gating
        gate_sel = 2'd1;
        expect_at(0, 1, 1'b1, "R13");
        sync_in = 1'b1;
        expect_at(1, 1, 1'b1, "R13");
        expect_at(2, 1, 1'b0, "R13");
        repeat (3) tick();
        gate_sel = 2'd2;
        expect_at(0, 1, 1'b1, "R13");
        sync_in = 1'b0;
        expect_at(2, 1, 1'b0, "R13");
        repeat (3) tick();
        gate_sel = 2'd3;
        expect_at(0, 1, 1'b1, "R13");
        tick();
        gate_sel = 2'd0;
        expect_at(0, 1, 1'b1, "R13");
        tick();

        repeat (5) tick();
        while (exp_q.size() != 0) tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule